// File: doc/BRIEF.md
# Redundant-Binary Multiply-Accumulate Unit

This block multiplies two signed 32-bit operands and adds the result into a 65-bit running sum. The multiplier recodes the second operand into sixteen radix-4 Booth digits and selects signed multiples of the first operand. Each pair of adjacent multiples becomes one redundant-binary row: the even multiple is the positive vector, and the negated odd multiple is the negative vector. There are eight such rows. They are summed by a binary tree of carry-free redundant-binary adders. The tree's single remaining row is turned into an ordinary 64-bit two's complement product by one two-operand subtraction.

The product is sign-extended to 65 bits. A ripple-carry adder adds it to the accumulator register, whose output feeds back as the adder's second input. Software or a sequencer presents one operand pair per cycle with a valid strobe. A synchronous clear restarts the sum.

Top module: `rbmac32`

## Requirements
- R1: While the active-low asynchronous reset `rst_n` is low, `acc` reads zero.
- R2: The internal product equals the exact signed 64-bit product of `op_a` and `op_b`, with both operands read as two's complement. This holds for the extreme operands, for example -2^31 times -2^31 gives 2^62.
- R3: When `in_valid` is high and `clr` is low at a clock edge, `acc` after that edge equals its previous value plus the sign-extended product of the operands sampled at that edge. The latency is one cycle.
- R4: When both `in_valid` and `clr` are low at a clock edge, `acc` keeps its value, whatever the operands are.
- R5: When `clr` is high at a clock edge, `acc` becomes zero after that edge, even if `in_valid` is also high.
- R6: The accumulator wraps modulo 2^65. For example, four accumulations of 2^62 from zero give the 65-bit pattern with only bit 64 set.
- R7: The partial products form eight redundant-binary rows. They are reduced by exactly three levels of carry-free adders. The value of each digit pair (plus, minus) is plus minus minus, so a pair with both bits set counts as zero. The root row's positive vector minus its negative vector equals the signed product modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the accumulator, has priority over in_valid |
| in_valid | input | 1 | Operand pair is accepted at this edge |
| op_a | input | 32 | Multiplicand, signed |
| op_b | input | 32 | Multiplier, signed, Booth recoded |
| acc | output | 65 | Accumulated sum, two's complement |

## Verification
The bench targets the most negative operand in both positions. An error in the Booth recoding of the top digit, or in the widening of a doubled multiple, would give a product off by a power of two or with the wrong sign.

It drives `clr` together with `in_valid` to show that clear wins. A reversed priority would leave the product in the sum. It also changes the operands while `in_valid` is low, which would expose a register that loads regardless of the strobe.

Repeated 2^62 products carry the sum past bit 63. A product that was not sign-extended, or a 64-bit accumulator, would then differ from the model. Long random runs with negative products check that the constant corrections in the redundant adders cancel exactly, since any mistake there leaves a fixed offset of a few units per product.

// File: rtl/rbmac32.sv
module rbmac32 #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W:0]   acc
);
  localparam int PW   = 2 * W;
  localparam int AW   = PW + 1;
  localparam int TW   = W + 2;
  localparam int DIG  = W / 2;
  localparam int ROWS = W / 4;
  localparam int NODE = 2 * ROWS - 1;

  logic [TW-1:0] a1, a2, na1, na2;
  assign a1  = {{2{op_a[W-1]}}, op_a};
  assign a2  = {a1[TW-2:0], 1'b0};
  assign na1 = -a1;
  assign na2 = -a2;

  // term[j] is +d*A for even j, -d*A for odd j (goes to the minus vector)
  logic [TW-1:0] term [DIG];

  for (genvar j = 0; j < DIG; j++) begin : g_booth
    logic [2:0] grp;
    if (j == 0) begin : g_first
      assign grp = {op_b[1:0], 1'b0};
    end else begin : g_rest
      assign grp = op_b[2*j+1:2*j-1];
    end
    logic [TW-1:0] one_p, one_n, two_p, two_n;
    if (j % 2 == 0) begin : g_pos
      assign one_p = a1;  assign one_n = na1;
      assign two_p = a2;  assign two_n = na2;
    end else begin : g_neg
      assign one_p = na1; assign one_n = a1;
      assign two_p = na2; assign two_n = a2;
    end
    always_comb begin
      case (grp)
        3'b001, 3'b010: term[j] = one_p;
        3'b011:         term[j] = two_p;
        3'b100:         term[j] = two_n;
        3'b101, 3'b110: term[j] = one_n;
        default:        term[j] = '0;
      endcase
    end
  end

  // heap-ordered tree of RB rows: root 0, leaves ROWS-1 .. NODE-1
  logic [PW-1:0] np [NODE];
  logic [PW-1:0] nn [NODE];

  for (genvar k = 0; k < ROWS; k++) begin : g_leaf
    logic [PW-1:0] ep, en;
    assign ep = {{(PW-TW){term[2*k][TW-1]}}, term[2*k]};
    assign en = {{(PW-TW){term[2*k+1][TW-1]}}, term[2*k+1]};
    assign np[ROWS-1+k] = ep << (4*k);
    assign nn[ROWS-1+k] = en << (4*k+2);
  end

  for (genvar i = 0; i < ROWS - 1; i++) begin : g_rbadd
    logic [PW-1:0] xp, xn_i, yp, yn_i, u, hs, s;
    logic [PW-2:0] h, c;
    assign xp   = np[2*i+1];
    assign xn_i = ~nn[2*i+1];
    assign yp   = np[2*i+2];
    assign yn_i = ~nn[2*i+2];
    assign u    = xp ^ xn_i ^ yp;
    assign h    = (xp[PW-2:0] & xn_i[PW-2:0]) | (xp[PW-2:0] & yp[PW-2:0])
                | (xn_i[PW-2:0] & yp[PW-2:0]);
    assign hs   = {h, 1'b0};
    assign s    = u ^ hs ^ yn_i;
    assign c    = (u[PW-2:0] & hs[PW-2:0]) | (u[PW-2:0] & yn_i[PW-2:0])
                | (hs[PW-2:0] & yn_i[PW-2:0]);
    assign np[i] = s;
    assign nn[i] = ~{c, 1'b1};
  end

  logic [PW-1:0] prod;
  assign prod = np[0] + ~nn[0] + PW'(1);

  logic [AW-1:0] addend, sum;
  logic [AW-1:0] cy;
  assign addend = {prod[PW-1], prod};
  assign cy[0]  = 1'b0;

  for (genvar b = 0; b < AW; b++) begin : g_ripple
    assign sum[b] = addend[b] ^ acc[b] ^ cy[b];
    if (b < AW - 1) begin : g_carry
      assign cy[b+1] = (addend[b] & acc[b]) | (addend[b] & cy[b]) | (acc[b] & cy[b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (clr)      acc <= '0;
    else if (in_valid) acc <= sum;
  end
endmodule

// File: rtl/rbmac32_chk.sv
module rbmac32_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [2*W:0]   acc,
  input logic [2*W-1:0] prod,
  input logic [2*W-1:0] root_p,
  input logic [2*W-1:0] root_n
);
  logic signed [2*W-1:0] xa, xb, want;
  assign xa   = {{W{op_a[W-1]}}, op_a};
  assign xb   = {{W{op_b[W-1]}}, op_b};
  assign want = xa * xb;

  assert_reset_zero_R1: assert property (@(posedge clk) !rst_n |-> acc == '0);

  assert_prod_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    prod == want);

  assert_tree_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (root_p - root_n) == want);

  assert_accumulate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !clr) |=> acc == $past(acc) + {$past(want[2*W-1]), $past(want)});

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> $stable(acc));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0);
endmodule

bind rbmac32 rbmac32_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
  .op_a(op_a), .op_b(op_b), .acc(acc), .prod(prod),
  .root_p(np[0]), .root_n(nn[0])
);

// File: tb/rbmac32_tb.sv
`timescale 1ns/1ps
module rbmac32_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [64:0] acc;

  int n_chk = 0;
  int n_bad = 0;
  logic [64:0] model = '0;

  always #2.5 clk = ~clk;

  rbmac32 u_dut (.clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid),
                 .op_a(op_a), .op_b(op_b), .acc(acc));

  function automatic logic [63:0] mulref(input logic [31:0] x, input logic [31:0] y);
    logic signed [63:0] xx, yy;
    xx = {{32{x[31]}}, x};
    yy = {{32{y[31]}}, y};
    return xx * yy;
  endfunction

  task automatic check(input logic [64:0] exp, input string tag);
    n_chk++;
    if (acc !== exp) begin
      n_bad++;
      $display("FAIL %s: acc=%h expected=%h", tag, acc, exp);
    end
  endtask

  task automatic step(input logic c, input logic v, input logic [31:0] a,
                      input logic [31:0] b, input string tag);
    logic [63:0] p;
    clr = c; in_valid = v; op_a = a; op_b = b;
    p = mulref(a, b);
    @(posedge clk);
    if (c) model = '0;
    else if (v) model = model + {p[63], p};
    @(negedge clk);
    check(model, tag);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: acc=%h expected=finished run", acc);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    op_a = 32'h1234_5678; op_b = 32'h9abc_def0; in_valid = 1'b1;
    repeat (3) @(negedge clk);
    check('0, "R1 reset holds zero");
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check('0, "R1 zero after reset release");

    step(1'b0, 1'b1, 32'd3, 32'd4, "R3 small positive");
    check(65'd12, "R3 explicit 3*4");
    step(1'b0, 1'b1, 32'hFFFF_FFFB, 32'd7, "R2 negative times positive");
    check(-65'sd23, "R2 explicit 12-35");
    step(1'b0, 1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D, "R4 hold with new operands");
    check(-65'sd23, "R4 explicit hold value");
    step(1'b1, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R5 clear beats valid");
    check('0, "R5 explicit zero");

    step(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R2 min times min");
    check(65'h0_4000_0000_0000_0000, "R2 explicit 2^62");
    step(1'b1, 1'b0, 32'd0, 32'd0, "R5 clear alone");
    step(1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R2 min times max");
    step(1'b0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2 minus one squared");
    step(1'b0, 1'b1, 32'hAAAA_AAAA, 32'h5555_5555, "R7 alternating digits");
    step(1'b0, 1'b1, 32'h5555_5555, 32'hAAAA_AAAA, "R7 alternating swapped");

    step(1'b1, 1'b0, 32'd0, 32'd0, "R5 clear before wrap");
    for (int i = 0; i < 4; i++)
      step(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R6 climb to wrap");
    check(65'h1_0000_0000_0000_0000, "R6 explicit 2^64 pattern");
    step(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R6 past wrap");
    step(1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, "R4 hold after wrap");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      logic [3:0] sel;
      ra = $urandom; rb = $urandom; sel = 4'($urandom);
      if (sel[1:0] == 2'b00) ra = {ra[31], 31'($urandom) & 31'h0000_000F};
      step(sel == 4'hF, sel[3:2] != 2'b00, ra, rb, "R3 R7 random accumulate");
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule